// File: doc/BRIEF.md
# Two-Level Arrival-Order Bus Arbiter

This block is a clocked central arbiter that hands bus tenure to one of fourteen modules at a time. Every module drives an urgent (level-1) request line and a normal (level-0) request line, and receives one grant line. Within each level the arbiter serves requesters strictly in the order their requests arrived. Normal requests are served only when no urgent request is pending anywhere.

Request inputs are first resynchronised through flop chains. Arrival order is then recorded as two queues of module indices, one queue per level. The arbiter holds a grant until the granted module has dropped both of its request lines. A new grant is picked only while the enable input is high and the grant-inhibit input, driven by the reset-duration monitor, is low. A grant that is already held survives the loss of enable.

Top module: `fcfs_bus_arbiter`

## Requirements
- R1: After a synchronous reset, every grant output and the any-grant output are low.
- R2: At most one bit of the grant vector is high in any cycle.
- R3: Within a level, grants follow the order in which requests rose after synchronisation. Requests that rise in the same cycle are ordered by lowest module index first. The line a module occupies confers no other priority.
- R4: A level-0 requester is never granted while any ungranted module holds its level-1 request.
- R5: A grant stays high until both request lines of that module are low. Only after the grant has dropped is the next grant chosen.
- R6: No new grant is issued while enable is low. A grant already held when enable falls remains until its requests drop.
- R7: A module that withdraws its request before being granted is removed from the order and is not granted.
- R8: The any-grant output is high exactly when some grant bit is high.
- R9: A module that holds its level-0 request and then also raises its level-1 request is ordered and served as a level-1 requester.
- R10: While grant-inhibit is high, no new grant is issued, just as when enable is low.
- R11: Reset empties both queues. Requests still held when reset ends are re-ordered as simultaneous arrivals, lowest index first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Allows new grants when high |
| inhibit_i | input | 1 | Blocks new grants when high (from the reset-duration monitor) |
| req_hi_i | input | 14 | Level-1 request per module, asynchronous |
| req_lo_i | input | 14 | Level-0 request per module, asynchronous |
| grant_o | output | 14 | One-hot grant per module |
| any_grant_o | output | 1 | High while any grant is high |

## Verification
The bench builds waiting populations with enable held low, so that the order the queues recorded is what it observes afterwards. A sweep staggers four arrivals per trial, in index orders produced by several strides modulo fourteen, alternately on each level. A pure index-priority or round-robin arbiter would reorder these, while the arrival-order arbiter must not. Further patterns set a simultaneous arrival against index tie-breaking, mixed levels against urgent-first service, and a normal-to-urgent upgrade against a stale queue entry. A withdrawal tests queue removal. A reset taken while requests are held separates rebuilt order from the order before the reset.

// File: rtl/fcfs_arb_pkg.sv
package fcfs_arb_pkg;

    localparam int NUM_MOD_DEF     = 14;
    localparam int SYNC_STAGES_DEF = 2;

    // Phase of the grant register: open for a new pick, or held by a module.
    typedef enum logic {
        PH_OPEN = 1'b0,
        PH_HELD = 1'b1
    } arb_phase_t;

    function automatic int idx_width(input int n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/fcfs_req_sync.sv
module fcfs_req_sync #(
    parameter int W      = 28,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/fcfs_order_queue.sv
module fcfs_order_queue #(
    parameter int N  = 14,
    parameter int IW = 4,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  rise_i,
    input  logic [N-1:0]  fall_i,
    output logic          head_valid_o,
    output logic [IW-1:0] head_idx_o
);

    logic [IW-1:0] slot_q [N];
    logic [IW-1:0] slot_d [N];
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    int            fill;

    // Survivors keep their relative age; new arrivals append lowest index first.
    always_comb begin
        fill = 0;
        for (int i = 0; i < N; i++) slot_d[i] = '0;
        for (int i = 0; i < N; i++) begin
            if (CW'(i) < cnt_q && !fall_i[slot_q[i]] && fill < N) begin
                slot_d[fill] = slot_q[i];
                fill = fill + 1;
            end
        end
        for (int m = 0; m < N; m++) begin
            if (rise_i[m] && fill < N) begin
                slot_d[fill] = IW'(m);
                fill = fill + 1;
            end
        end
        cnt_d = CW'(fill);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < N; i++) slot_q[i] <= '0;
        end else begin
            cnt_q <= cnt_d;
            for (int i = 0; i < N; i++) slot_q[i] <= slot_d[i];
        end
    end

    assign head_valid_o = (cnt_q != '0);
    assign head_idx_o   = slot_q[0];

    // R3: the oldest entry keeps the head until it leaves
    p_head_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (head_valid_o && !fall_i[head_idx_o]) |=> (head_valid_o && head_idx_o == $past(head_idx_o)));

    // R7: a withdrawn head is gone on the next cycle
    p_head_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (head_valid_o && fall_i[head_idx_o]) |=> !(head_valid_o && head_idx_o == $past(head_idx_o)));

endmodule

// File: rtl/fcfs_bus_arbiter.sv
module fcfs_bus_arbiter
    import fcfs_arb_pkg::*;
#(
    parameter int NUM_MOD     = NUM_MOD_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable_i,
    input  logic               inhibit_i,
    input  logic [NUM_MOD-1:0] req_hi_i,
    input  logic [NUM_MOD-1:0] req_lo_i,
    output logic [NUM_MOD-1:0] grant_o,
    output logic               any_grant_o
);

    localparam int IW = idx_width(NUM_MOD);
    localparam int CW = $clog2(NUM_MOD + 1);

    logic [NUM_MOD-1:0] hi_s, lo_s;
    logic [NUM_MOD-1:0] hi_act, lo_act, hi_prev, lo_prev;
    logic [NUM_MOD-1:0] hi_rise, hi_fall, lo_rise, lo_fall;
    logic [NUM_MOD-1:0] grant_q, grant_d;
    logic               hi_hv, lo_hv;
    logic [IW-1:0]      hi_head, lo_head;
    arb_phase_t         phase;
    logic               may_pick;

    fcfs_req_sync #(.W(2*NUM_MOD), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({req_hi_i, req_lo_i}),
        .q_o ({hi_s, lo_s})
    );

    // A module waits on the urgent level if its level-1 line is up,
    // otherwise on the normal level; a granted module waits on neither.
    assign hi_act  = hi_s & ~grant_q;
    assign lo_act  = lo_s & ~hi_s & ~grant_q;
    assign hi_rise = hi_act & ~hi_prev;
    assign hi_fall = ~hi_act & hi_prev;
    assign lo_rise = lo_act & ~lo_prev;
    assign lo_fall = ~lo_act & lo_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_prev <= '0;
            lo_prev <= '0;
            grant_q <= '0;
        end else begin
            hi_prev <= hi_act;
            lo_prev <= lo_act;
            grant_q <= grant_d;
        end
    end

    fcfs_order_queue #(.N(NUM_MOD), .IW(IW), .CW(CW)) u_hi_q (
        .clk (clk), .rst (rst),
        .rise_i (hi_rise), .fall_i (hi_fall),
        .head_valid_o (hi_hv), .head_idx_o (hi_head)
    );

    fcfs_order_queue #(.N(NUM_MOD), .IW(IW), .CW(CW)) u_lo_q (
        .clk (clk), .rst (rst),
        .rise_i (lo_rise), .fall_i (lo_fall),
        .head_valid_o (lo_hv), .head_idx_o (lo_head)
    );

    assign phase    = (|grant_q) ? PH_HELD : PH_OPEN;
    assign may_pick = enable_i && !inhibit_i;

    always_comb begin
        grant_d = grant_q;
        if (phase == PH_HELD) begin
            if (!(|(grant_q & (hi_s | lo_s)))) grant_d = '0;
        end else if (may_pick) begin
            if (|hi_act) begin
                if (hi_hv && hi_act[hi_head]) grant_d = NUM_MOD'(1) << hi_head;
            end else if (lo_hv && lo_act[lo_head]) begin
                grant_d = NUM_MOD'(1) << lo_head;
            end
        end
    end

    assign grant_o     = grant_q;
    assign any_grant_o = (phase == PH_HELD);

    p_onehot_r2: assert property (@(posedge clk) disable iff (rst) $onehot0(grant_o));

    p_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (grant_q == '0 && !enable_i) |=> (grant_q == '0));

    p_inhibit_r10: assert property (@(posedge clk) disable iff (rst)
        (grant_q == '0 && inhibit_i) |=> (grant_q == '0));

    p_lo_wait_r4: assert property (@(posedge clk) disable iff (rst)
        (grant_q == '0 && |hi_act) |=> ((grant_q & ~$past(hi_act)) == '0));

    for (genvar g = 0; g < NUM_MOD; g++) begin : g_hold
        p_hold_r5: assert property (@(posedge clk) disable iff (rst)
            (grant_q[g] && (hi_s[g] || lo_s[g])) |=> grant_q[g]);
    end

endmodule

// File: tb/fcfs_bus_arbiter_test.sv
module fcfs_bus_arbiter_test;

    localparam int N = 14;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b0;
    logic         inh = 1'b0;
    logic [N-1:0] hi  = '0;
    logic [N-1:0] lo  = '0;
    logic [N-1:0] grant;
    logic         anyg;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    fcfs_bus_arbiter uut (
        .clk (clk), .rst (rst), .enable_i (en), .inhibit_i (inh),
        .req_hi_i (hi), .req_lo_i (lo), .grant_o (grant), .any_grant_o (anyg)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // m < 0 means no grant expected
    task automatic expect_grant(input int m, input string tag);
        logic [N-1:0] exp;
        exp = (m < 0) ? '0 : (N'(1) << m);
        chk(grant, exp, tag);
        chk(N'(anyg), N'(m >= 0), {tag, " R8 any-grant"});
        chk(N'($countones(grant) <= 1), N'(1), {tag, " R2 onehot"});
    endtask

    task automatic serve(input int m, input string tag);
        tick(8);
        expect_grant(m, tag);
        hi[m] = 1'b0;
        lo[m] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int ord [4];
        int s;
        tick(3);
        rst = 1'b0;
        tick(2);
        expect_grant(-1, "R1 reset");

        // R3 tie: simultaneous arrivals served lowest index first
        hi[11] = 1'b1; hi[4] = 1'b1; hi[7] = 1'b1;
        tick(4);
        en = 1'b1;
        serve(4, "R3 tie first");
        serve(7, "R3 tie second");
        serve(11, "R3 tie third");
        tick(8);
        expect_grant(-1, "R3 tie drained");

        // R3 sweep: staggered arrivals in computed orders, alternating level
        for (int t = 0; t < 5; t++) begin
            s = (t < 3) ? 2 * t + 1 : 2 * t + 3;
            en = 1'b0;
            for (int k = 0; k < 4; k++) begin
                ord[k] = (t * 5 + k * s) % N;
                if (t % 2 == 0) hi[ord[k]] = 1'b1;
                else            lo[ord[k]] = 1'b1;
                tick(3);
            end
            en = 1'b1;
            for (int k = 0; k < 4; k++) serve(ord[k], "R3 sweep");
            tick(8);
            expect_grant(-1, "R3 sweep drained");
        end

        // R4: level-1 served before older level-0
        en = 1'b0;
        lo[2] = 1'b1; tick(3);
        lo[6] = 1'b1; tick(3);
        hi[10] = 1'b1; tick(3);
        en = 1'b1;
        serve(10, "R4 urgent first");
        serve(2, "R4 normal oldest");
        serve(6, "R4 normal next");

        // R5: grant held while either line remains
        tick(8);
        hi[6] = 1'b1; lo[6] = 1'b1;
        tick(8);
        expect_grant(6, "R5 granted");
        hi[1] = 1'b1;
        hi[6] = 1'b0;
        tick(8);
        expect_grant(6, "R5 held on low line");
        lo[6] = 1'b0;
        serve(1, "R5 next after release");

        // R6: enable drop keeps held grant, blocks new ones
        tick(8);
        hi[3] = 1'b1;
        tick(8);
        expect_grant(3, "R6 granted");
        hi[10] = 1'b1;
        en = 1'b0;
        tick(8);
        expect_grant(3, "R6 held while disabled");
        hi[3] = 1'b0;
        tick(8);
        expect_grant(-1, "R6 no new grant while disabled");
        en = 1'b1;
        serve(10, "R6 re-enabled");

        // R10: inhibit blocks new grants
        tick(8);
        inh = 1'b1;
        hi[4] = 1'b1;
        tick(8);
        expect_grant(-1, "R10 inhibited");
        inh = 1'b0;
        serve(4, "R10 released");

        // R9: upgrade from level-0 to level-1
        tick(8);
        en = 1'b0;
        lo[5] = 1'b1; tick(3);
        lo[9] = 1'b1; tick(3);
        hi[9] = 1'b1; tick(3);
        en = 1'b1;
        serve(9, "R9 upgraded first");
        serve(5, "R9 normal after");

        // R7: withdrawal before grant
        tick(8);
        en = 1'b0;
        hi[1] = 1'b1; tick(3);
        hi[2] = 1'b1; tick(3);
        hi[3] = 1'b1; tick(3);
        hi[2] = 1'b0; tick(3);
        en = 1'b1;
        serve(1, "R7 first");
        serve(3, "R7 skips withdrawn");
        tick(8);
        expect_grant(-1, "R7 withdrawn never granted");

        // R11: reset rebuilds order by index
        en = 1'b0;
        hi[12] = 1'b1; tick(3);
        hi[2]  = 1'b1; tick(3);
        rst = 1'b1;
        tick(2);
        expect_grant(-1, "R1 R11 in reset");
        rst = 1'b0;
        tick(6);
        en = 1'b1;
        serve(2, "R11 lowest index after reset");
        serve(12, "R11 second");
        tick(8);
        expect_grant(-1, "R11 drained");

        summary();
        $finish;
    end

endmodule